// File: doc/BRIEF.md
# Sequential Radix-2 Booth Multiplier

This block multiplies two signed two's complement operands of `WIDTH` bits and returns their full `2*WIDTH`-bit signed product. It trades speed for area: a single add/subtract unit is reused over `WIDTH` iterations, one per clock. Each iteration looks at the lowest bit of the multiplier register and the bit that was shifted out of it on the step before. From that pair it decides to add the multiplicand, subtract it, or leave the accumulator unchanged. It then shifts the whole working register right by one place, keeping the sign.

The operands are captured on a `start` pulse while the unit is idle. `busy` stays high while the iterations run. A one-cycle `done` pulse marks the cycle in which `product` first shows the new result. `product` is a register and keeps its value until the next multiplication completes. A `start` in the `done` cycle is accepted, so operations can run back to back.

Top module: `booth_mult`

## Requirements
- R1: `product` equals the two's complement product of `multiplicand` and `multiplier`, both taken as signed `WIDTH`-bit values, for every operand pair. This includes the most negative value in either or both operands.
- R2: `done` is high in the cycle that comes `WIDTH`+1 clock cycles after the cycle in which `start` was accepted. The accepting cycle counts as cycle 0.
- R3: `busy` is high from the cycle after `start` is accepted up to and including the last iteration cycle. It is low in the `done` cycle.
- R4: `done` is high for exactly one cycle per multiplication.
- R5: A `start` that arrives while `busy` is high is ignored. It changes neither the result nor the completion time of the multiplication in progress.
- R6: `product` changes only in a `done` cycle. Changes on the operand inputs between multiplications have no effect on it.
- R7: While `rst` is high and after it is released, `busy` is 0, `done` is 0 and `product` is 0 until a multiplication completes.
- R8: A `start` asserted in the `done` cycle is accepted, and it yields a correct second result with the same latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiplication; accepted when `busy` is low |
| multiplicand | input | WIDTH | Signed multiplicand, captured on accepted start |
| multiplier | input | WIDTH | Signed multiplier, captured on accepted start |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2*WIDTH | Registered signed product |

## Verification
Two events can fall in the same cycle: the completion of one multiplication and the acceptance of the next `start`. The bench provokes this by holding `start` high with fresh operands through the `done` cycle. It then requires that the first product is intact, that the second product is correct, and that the second `done` arrives after the full latency. A second overlap comes from `start` pulses with decoy operands fired while `busy` is high. For these the bench judges that the result and its timing are those of the original operands. Around both cases, every signed operand pair of a 6-bit configuration is swept and compared against an arithmetic multiply.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } booth_op_e;
endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_pkg::*;
(
  input  logic      cur_bit,
  input  logic      prev_bit,
  output booth_op_e op
);
  // A run of ones begins (1,0): subtract. A run ends (0,1): add.
  always_comb begin
    unique case ({cur_bit, prev_bit})
      2'b10:   op = OP_SUB;
      2'b01:   op = OP_ADD;
      default: op = OP_HOLD;
    endcase
  end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int W = 9
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] operand,
  input  booth_op_e    op,
  output logic [W-1:0] result
);
  logic          sub;
  logic          use_op;
  logic [W-1:0]  addend;

  // A single adder serves both add and subtract (invert plus carry-in).
  always_comb begin
    sub    = (op == OP_SUB);
    use_op = (op != OP_HOLD);
    addend = use_op ? (operand ^ {W{sub}}) : '0;
    result = acc + addend + W'(sub);
  end
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
  parameter int STEPS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step,
  output logic last,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(STEPS + 1);
  logic [CW-1:0] cnt_q;

  assign load = start && !busy;
  assign step = busy;
  assign last = busy && (cnt_q == CW'(STEPS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt_q <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy  <= 1'b1;
        cnt_q <= '0;
      end else if (busy) begin
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/booth_mult.sv
module booth_mult
  import booth_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);
  localparam int AW = WIDTH + 1;

  logic [AW-1:0]    acc_q;
  logic [AW-1:0]    mcand_q;
  logic [WIDTH-1:0] mq_q;
  logic             xbit_q;
  logic [AW-1:0]    sum;
  logic [AW-1:0]    acc_nx;
  logic [WIDTH-1:0] mq_nx;
  logic             load;
  logic             step;
  logic             last;
  booth_op_e        op;

  booth_ctrl #(.STEPS(WIDTH)) ctrl_i (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .load  (load),
    .step  (step),
    .last  (last),
    .busy  (busy),
    .done  (done)
  );

  booth_recoder rec_i (
    .cur_bit  (mq_q[0]),
    .prev_bit (xbit_q),
    .op       (op)
  );

  booth_addsub #(.W(AW)) addsub_i (
    .acc     (acc_q),
    .operand (mcand_q),
    .op      (op),
    .result  (sum)
  );

  // Arithmetic right shift of {acc, mq, xbit} after the add/subtract.
  assign acc_nx = {sum[AW-1], sum[AW-1:1]};
  assign mq_nx  = {sum[0], mq_q[WIDTH-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      mcand_q <= '0;
      mq_q    <= '0;
      xbit_q  <= 1'b0;
      product <= '0;
    end else if (load) begin
      acc_q   <= '0;
      mcand_q <= {multiplicand[WIDTH-1], multiplicand};
      mq_q    <= multiplier;
      xbit_q  <= 1'b0;
    end else if (step) begin
      acc_q  <= acc_nx;
      mq_q   <= mq_nx;
      xbit_q <= mq_q[0];
      if (last) begin
        product <= {acc_nx[WIDTH-1:0], mq_nx};
      end
    end
  end
endmodule

// File: rtl/booth_mult_chk.sv
module booth_mult_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [2*N-1:0] product
);
  int run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= 0;
    end else if (start && !busy) begin
      run_cnt <= 0;
    end else if (busy) begin
      run_cnt <= run_cnt + 1;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R4

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R3

  AST_ACCEPT_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy); // R3

  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start)); // R5

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    done |-> (run_cnt == N)); // R2

  AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(product)); // R6
endmodule

bind booth_mult booth_mult_chk #(.N(WIDTH)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .product (product)
);

// File: tb/booth_mult_tb_top.sv
module booth_mult_tb_top;
  localparam int W  = 6;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [W-1:0]  mcand = '0;
  logic [W-1:0]  mplier = '0;
  logic          busy;
  logic          done;
  logic [PW-1:0] product;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  booth_mult #(.WIDTH(W)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .multiplicand (mcand),
    .multiplier   (mplier),
    .busy         (busy),
    .done         (done),
    .product      (product)
  );

  function automatic logic [PW-1:0] ref_mul(input int a, input int b);
    int p;
    p = a * b;
    return p[PW-1:0];
  endfunction

  task automatic check(input string req, input logic [PW-1:0] act,
                       input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Start at a negedge, drop start after the accepting edge, count edges
  // until done is seen at a negedge.
  task automatic run(input int a, input int b, output int lat);
    mcand  = W'(a);
    mplier = W'(b);
    start  = 1'b1;
    lat    = 0;
    do begin
      @(posedge clk);
      @(negedge clk);
      if (lat == 0) start = 1'b0;
      lat++;
    end while (!done && lat < 40);
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    int lat;
    logic [PW-1:0] held;
    repeat (3) @(negedge clk);
    // R7: reset state.
    check("R7 busy", PW'(busy), '0);
    check("R7 done", PW'(done), '0);
    check("R7 product", product, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R7 after release", {product[PW-1:2], busy, done}, '0);

    // R1: exhaustive signed sweep; R2 latency on every run.
    for (int a = -(1 << (W-1)); a < (1 << (W-1)); a++) begin
      for (int b = -(1 << (W-1)); b < (1 << (W-1)); b++) begin
        run(a, b, lat);
        check("R1 product", product, ref_mul(a, b));
        if (lat != W + 1) check("R2 latency", PW'(lat), PW'(W + 1));
      end
    end
    check("R2 latency", PW'(lat), PW'(W + 1));

    // R1: most negative times most negative.
    run(-(1 << (W-1)), -(1 << (W-1)), lat);
    check("R1 min*min", product, ref_mul(-(1 << (W-1)), -(1 << (W-1))));

    // R4: done drops after one cycle; R3: busy low in done cycle.
    check("R3 busy in done cycle", PW'(busy), '0);
    @(negedge clk);
    check("R4 done width", PW'(done), '0);

    // R6: product holds while inputs wander.
    held = product;
    mcand = 6'h15; mplier = 6'h2a;
    repeat (5) @(negedge clk);
    check("R6 product hold", product, held);

    // R5: start pulses while busy with decoy operands.
    mcand = W'(-7); mplier = W'(11); start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0; lat = 1;
    check("R3 busy after accept", PW'(busy), PW'(1));
    repeat (2) begin
      mcand = W'(31); mplier = W'(-32); start = 1'b1;
      @(posedge clk); @(negedge clk);
      start = 1'b0; lat++;
    end
    while (!done && lat < 40) begin
      @(posedge clk); @(negedge clk); lat++;
    end
    check("R5 ignored start result", product, ref_mul(-7, 11));
    check("R5 ignored start latency", PW'(lat), PW'(W + 1));

    // R8: start held through the done cycle.
    mcand = W'(-13); mplier = W'(-5); start = 1'b1;
    lat = 0;
    do begin
      @(posedge clk); @(negedge clk); lat++;
    end while (!done && lat < 40);
    check("R8 first result", product, ref_mul(-13, -5));
    mcand = W'(9); mplier = W'(-21);
    @(posedge clk); @(negedge clk);
    start = 1'b0; lat = 1;
    check("R8 accepted in done cycle", PW'(busy), PW'(1));
    while (!done && lat < 40) begin
      @(posedge clk); @(negedge clk); lat++;
    end
    check("R8 second result", product, ref_mul(9, -21));
    check("R8 second latency", PW'(lat), PW'(W + 1));

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule